// File: doc/BRIEF.md
# Virtual-Wire Handshake Responder

This block is the answering side of the sideband virtual-wire handshakes between a platform controller (the host side) and a management device. The host raises warn levels before it resets the host domain, resets the out-of-band domain, or enters suspend. The block answers each warn with its own ack wire. It also raises the pair of boot-complete indications that the host waits for before leaving full power-off. All outgoing wires are registered and packed into two 32-bit event words at fixed bit positions, which a separate wire serialiser picks up.

The two reset acks are raised only once the matching upstream queue reports that it has quiesced. A separate flush engine drives the two quiesce-done inputs. The suspend ack needs no such condition: the host stalls until it arrives, so it is answered as soon as it is seen.

A hardware-reset pulse from the link clears every outgoing wire. It then drives the 8-bit soft-reset field low for a set number of cycles and returns it high. After that the block re-evaluates every warn and the boot condition, so a warn that is still held is answered again.

The block also reports the platform-reset level. The level counts as unknown until the host first reports it. After that the block keeps the last reported value and raises a one-cycle change pulse whenever that value moves.

Top module: `vw_handshake_responder`

## Requirements
- R1: While host_rst_warn is high and periph_quiesced is high, bit 27 of evt_word0 becomes 1 one clock after both are seen. It stays 0 while periph_quiesced is low.
- R2: While oob_rst_warn is high and oob_quiesced is high, bit 16 of evt_word0 becomes 1 one clock later. It stays 0 while oob_quiesced is low, whatever periph_quiesced is.
- R3: When sus_warn is high, bit 20 of evt_word1 becomes 1 one clock later, with no quiesce condition.
- R4: Each ack returns to 0 one clock after its warn input is seen low.
- R5: Bit 20 (boot done) and bit 23 (boot status) of evt_word0 always hold equal values. Both become 1 in the same clock, one clock after a cycle in which the block is not busy, pwr_off is low and boot status is clear.
- R6: While pwr_off is high, both boot bits are 0 from the clock after it is seen. They are set again one clock after pwr_off falls.
- R7: The clock edge that samples hw_reset_pulse high clears every bit of both event words and drives soft_rst_field to all zeros. The field stays all zeros for SRST_LOW_CYC cycles and then returns to all ones. All ones is its value at reset and when idle.
- R8: Counting the edge that samples hw_reset_pulse as edge 0, no outgoing wire is raised before edge SRST_LOW_CYC+2. At that edge, warns still held (with their quiesce inputs) are answered again and the boot bits are set again.
- R9: After reset, plat_rst_known and plat_rst_val are 0. The first plat_rst_upd strobe sets plat_rst_known to 1 and copies plat_rst_lvl to plat_rst_val one clock later, with a one-cycle plat_rst_chg pulse, whichever level is reported.
- R10: A later plat_rst_upd with the same level leaves plat_rst_chg low. One with a different level updates plat_rst_val and pulses plat_rst_chg for exactly one cycle.
- R11: All bits of evt_word0 other than 27, 23, 20 and 16, and all bits of evt_word1 other than 20, are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rst_warn | input | 1 | Sampled host-domain reset warn level |
| oob_rst_warn | input | 1 | Sampled out-of-band reset warn level |
| sus_warn | input | 1 | Sampled suspend warn level |
| periph_quiesced | input | 1 | Peripheral upstream queue has been flushed |
| oob_quiesced | input | 1 | Out-of-band upstream queue has been flushed |
| pwr_off | input | 1 | Platform is in full power-off |
| hw_reset_pulse | input | 1 | One-cycle link hardware-reset event |
| plat_rst_lvl | input | 1 | Platform-reset level carried by the host's report |
| plat_rst_upd | input | 1 | Strobe: host has reported the platform-reset level |
| evt_word0 | output | 32 | Outgoing event word: host ack 27, boot status 23, boot done 20, out-of-band ack 16 |
| evt_word1 | output | 32 | Outgoing event word: suspend ack 20 |
| soft_rst_field | output | 8 | Controller soft-reset field, all ones when idle |
| plat_rst_val | output | 1 | Last reported platform-reset level |
| plat_rst_known | output | 1 | Platform-reset level has been reported |
| plat_rst_chg | output | 1 | One-cycle pulse when the reported level changes |

## Verification
On every cycle the assertions check the following. An ack rises only after its warn and quiesce inputs were high, and it falls after its warn drops. The two boot bits never differ. A reset pulse always zeroes the soft-reset field and the wires on the next cycle. The change pulse never appears while the level is unknown. Only the directed scenarios can show the exact latencies: the field staying low for precisely SRST_LOW_CYC cycles, re-answering held warns at edge SRST_LOW_CYC+2, the separation of the two quiesce inputs, and the first report from the unknown state for each level.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  // Bit positions inside the outgoing event words, decoded by the serialiser
  localparam int EVT_W          = 32;
  localparam int HOST_ACK_BIT   = 27;
  localparam int BOOT_STAT_BIT  = 23;
  localparam int BOOT_DONE_BIT  = 20;
  localparam int OOB_ACK_BIT    = 16;
  localparam int SUS_ACK_BIT    = 20;

  // Indices of the handshake lanes
  localparam int LANE_HOST = 0;
  localparam int LANE_OOB  = 1;
  localparam int LANE_SUS  = 2;
  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_HOLD    = 2'd1,
    SEQ_RELEASE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vwr_ack_cell.sv
module vwr_ack_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic allow,
  input  logic warn,
  input  logic gate,
  output logic ack
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !warn) begin
      ack_q <= 1'b0;
    end else if (allow && gate) begin
      ack_q <= 1'b1;
    end
  end

  assign ack = ack_q;

  // R1 R2 R3: an ack only rises after its warn and its quiesce gate were high
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(warn) && $past(gate)));

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !warn |=> !ack);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !ack);
endmodule

// File: rtl/vwr_reset_seq.sv
module vwr_reset_seq
  import vwr_pkg::*;
#(
  parameter int SRST_W       = 8,
  parameter int SRST_LOW_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_pulse,
  output logic [SRST_W-1:0] srst_field,
  output logic              busy
);
  localparam int CNT_W = $clog2(SRST_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SRST_LOW_CYC - 1);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SRST_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      field_q <= '1;
    end else if (hw_pulse) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      field_q <= '0;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          if (cnt_q == LAST_CNT) begin
            state_q <= SEQ_RELEASE;
            field_q <= '1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_RELEASE: state_q <= SEQ_IDLE;
        default:     state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign srst_field = field_q;
  assign busy       = (state_q != SEQ_IDLE);

  // R7
  srst_low_chk: assert property (@(posedge clk) disable iff (rst)
    hw_pulse |=> (srst_field == '0));

  // R8: the field returns high while the block is still busy
  srst_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(srst_field) == '0 && srst_field == '1) |-> busy);
endmodule

// File: rtl/vwr_boot_flags.sv
module vwr_boot_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic allow,
  input  logic pwr_off,
  output logic boot_done,
  output logic boot_status
);
  logic done_q;
  logic stat_q;

  always_ff @(posedge clk) begin
    if (rst || clr || pwr_off) begin
      done_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (allow && !stat_q) begin
      done_q <= 1'b1;
      stat_q <= 1'b1;
    end
  end

  assign boot_done   = done_q;
  assign boot_status = stat_q;

  // R5
  boot_pair_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done == boot_status);

  // R6
  boot_pwroff_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_off |=> !boot_done);
endmodule

// File: rtl/vwr_plat_rst_track.sv
module vwr_plat_rst_track (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic lvl,
  output logic val,
  output logic known,
  output logic chg
);
  logic val_q, known_q, chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= 1'b0;
      known_q <= 1'b0;
      chg_q   <= 1'b0;
    end else if (upd) begin
      val_q   <= lvl;
      known_q <= 1'b1;
      chg_q   <= !known_q || (val_q != lvl);
    end else begin
      chg_q   <= 1'b0;
    end
  end

  assign val   = val_q;
  assign known = known_q;
  assign chg   = chg_q;

  // R9
  chg_known_chk: assert property (@(posedge clk) disable iff (rst)
    chg |-> known);

  // R9
  first_report_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(known) |-> chg);

  // R10
  chg_single_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (!chg || $past(upd)));
endmodule

// File: rtl/vw_handshake_responder.sv
module vw_handshake_responder
  import vwr_pkg::*;
#(
  parameter int SRST_W       = 8,
  parameter int SRST_LOW_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rst_warn,
  input  logic              oob_rst_warn,
  input  logic              sus_warn,
  input  logic              periph_quiesced,
  input  logic              oob_quiesced,
  input  logic              pwr_off,
  input  logic              hw_reset_pulse,
  input  logic              plat_rst_lvl,
  input  logic              plat_rst_upd,
  output logic [EVT_W-1:0]  evt_word0,
  output logic [EVT_W-1:0]  evt_word1,
  output logic [SRST_W-1:0] soft_rst_field,
  output logic              plat_rst_val,
  output logic              plat_rst_known,
  output logic              plat_rst_chg
);
  logic                 seq_busy;
  logic                 allow;
  logic [NUM_LANES-1:0] warn_vec;
  logic [NUM_LANES-1:0] gate_vec;
  logic [NUM_LANES-1:0] ack_vec;
  logic                 boot_done, boot_status;

  assign allow = !seq_busy && !hw_reset_pulse;

  assign warn_vec[LANE_HOST] = host_rst_warn;
  assign warn_vec[LANE_OOB]  = oob_rst_warn;
  assign warn_vec[LANE_SUS]  = sus_warn;
  assign gate_vec[LANE_HOST] = periph_quiesced;
  assign gate_vec[LANE_OOB]  = oob_quiesced;
  assign gate_vec[LANE_SUS]  = 1'b1;

  vwr_reset_seq #(
    .SRST_W       (SRST_W),
    .SRST_LOW_CYC (SRST_LOW_CYC)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .hw_pulse   (hw_reset_pulse),
    .srst_field (soft_rst_field),
    .busy       (seq_busy)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    vwr_ack_cell cell_i (
      .clk   (clk),
      .rst   (rst),
      .clr   (hw_reset_pulse),
      .allow (allow),
      .warn  (warn_vec[g]),
      .gate  (gate_vec[g]),
      .ack   (ack_vec[g])
    );
  end

  vwr_boot_flags boot_i (
    .clk         (clk),
    .rst         (rst),
    .clr         (hw_reset_pulse),
    .allow       (allow),
    .pwr_off     (pwr_off),
    .boot_done   (boot_done),
    .boot_status (boot_status)
  );

  vwr_plat_rst_track plat_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (plat_rst_upd),
    .lvl   (plat_rst_lvl),
    .val   (plat_rst_val),
    .known (plat_rst_known),
    .chg   (plat_rst_chg)
  );

  always_comb begin
    evt_word0                = '0;
    evt_word0[HOST_ACK_BIT]  = ack_vec[LANE_HOST];
    evt_word0[OOB_ACK_BIT]   = ack_vec[LANE_OOB];
    evt_word0[BOOT_DONE_BIT] = boot_done;
    evt_word0[BOOT_STAT_BIT] = boot_status;
    evt_word1                = '0;
    evt_word1[SUS_ACK_BIT]   = ack_vec[LANE_SUS];
  end

  // R8: nothing is raised while the soft-reset sequence is running
  quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> (evt_word1 == '0 && !evt_word0[HOST_ACK_BIT]));
endmodule

// File: tb/vw_handshake_responder_tb.sv
module vw_handshake_responder_tb_top;
  localparam int LOWC = 4;
  localparam logic [31:0] B_HOST = 32'h1 << 27;
  localparam logic [31:0] B_STAT = 32'h1 << 23;
  localparam logic [31:0] B_DONE = 32'h1 << 20;
  localparam logic [31:0] B_OOB  = 32'h1 << 16;
  localparam logic [31:0] B_SUS  = 32'h1 << 20;
  localparam logic [31:0] BOOT   = B_STAT | B_DONE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_rst_warn = 0, oob_rst_warn = 0, sus_warn = 0;
  logic periph_quiesced = 0, oob_quiesced = 0, pwr_off = 1;
  logic hw_reset_pulse = 0, plat_rst_lvl = 0, plat_rst_upd = 0;
  logic [31:0] evt_word0, evt_word1;
  logic [7:0]  soft_rst_field;
  logic plat_rst_val, plat_rst_known, plat_rst_chg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vw_handshake_responder #(.SRST_W(8), .SRST_LOW_CYC(LOWC)) dut_i (
    .clk(clk), .rst(rst),
    .host_rst_warn(host_rst_warn), .oob_rst_warn(oob_rst_warn),
    .sus_warn(sus_warn), .periph_quiesced(periph_quiesced),
    .oob_quiesced(oob_quiesced), .pwr_off(pwr_off),
    .hw_reset_pulse(hw_reset_pulse), .plat_rst_lvl(plat_rst_lvl),
    .plat_rst_upd(plat_rst_upd), .evt_word0(evt_word0),
    .evt_word1(evt_word1), .soft_rst_field(soft_rst_field),
    .plat_rst_val(plat_rst_val), .plat_rst_known(plat_rst_known),
    .plat_rst_chg(plat_rst_chg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; pwr_off = 1;
    host_rst_warn = 0; oob_rst_warn = 0; sus_warn = 0;
    periph_quiesced = 0; oob_quiesced = 0; plat_rst_upd = 0;
    step(3);
    chk("R11 reset word0", evt_word0, 32'h0);
    chk("R11 reset word1", evt_word1, 32'h0);
    chk("R7 reset field", {24'h0, soft_rst_field}, 32'hff);
    chk("R9 reset known", {31'h0, plat_rst_known}, 32'h0);
    chk("R9 reset val", {31'h0, plat_rst_val}, 32'h0);
    rst = 0;
    step(1);
    chk("R6 boot held off", evt_word0, 32'h0);
    pwr_off = 0;
    step(1);
    chk("R5 boot pair set", evt_word0, BOOT);
  endtask

  task automatic t_host();
    host_rst_warn = 1; periph_quiesced = 0;
    step(2);
    chk("R1 no ack unquiesced", evt_word0, BOOT);
    periph_quiesced = 1;
    step(1);
    chk("R1 host ack", evt_word0, BOOT | B_HOST);
    host_rst_warn = 0;
    step(1);
    chk("R4 host ack drop", evt_word0, BOOT);
    periph_quiesced = 0;
  endtask

  task automatic t_oob();
    oob_rst_warn = 1; periph_quiesced = 1; oob_quiesced = 0;
    step(2);
    chk("R2 no ack wrong gate", evt_word0, BOOT);
    oob_quiesced = 1;
    step(1);
    chk("R2 oob ack", evt_word0, BOOT | B_OOB);
    chk("R11 word1 idle", evt_word1, 32'h0);
    oob_rst_warn = 0;
    step(1);
    chk("R4 oob ack drop", evt_word0, BOOT);
    periph_quiesced = 0; oob_quiesced = 0;
  endtask

  task automatic t_sus();
    sus_warn = 1;
    step(1);
    chk("R3 sus ack", evt_word1, B_SUS);
    chk("R11 word0 unchanged", evt_word0, BOOT);
    sus_warn = 0;
    step(1);
    chk("R4 sus ack drop", evt_word1, 32'h0);
  endtask

  task automatic t_pwr();
    pwr_off = 1;
    step(1);
    chk("R6 boot cleared", evt_word0, 32'h0);
    step(3);
    chk("R6 boot stays clear", evt_word0, 32'h0);
    pwr_off = 0;
    step(1);
    chk("R6 boot re-set", evt_word0, BOOT);
  endtask

  task automatic t_hwrst();
    host_rst_warn = 1; periph_quiesced = 1; sus_warn = 1;
    step(1);
    chk("R1 pre ack", evt_word0, BOOT | B_HOST);
    hw_reset_pulse = 1;
    step(1);
    hw_reset_pulse = 0;
    chk("R7 field low", {24'h0, soft_rst_field}, 32'h0);
    chk("R7 word0 cleared", evt_word0, 32'h0);
    chk("R7 word1 cleared", evt_word1, 32'h0);
    for (int k = 1; k < LOWC; k++) begin
      step(1);
      chk("R7 field held low", {24'h0, soft_rst_field}, 32'h0);
    end
    step(1);
    chk("R7 field restored", {24'h0, soft_rst_field}, 32'hff);
    chk("R8 quiet at release", evt_word0 | evt_word1, 32'h0);
    step(1);
    chk("R8 quiet one more", evt_word0 | evt_word1, 32'h0);
    step(1);
    chk("R8 re-answer word0", evt_word0, BOOT | B_HOST);
    chk("R8 re-answer word1", evt_word1, B_SUS);
    host_rst_warn = 0; sus_warn = 0; periph_quiesced = 0;
    step(1);
  endtask

  task automatic upd(input logic l);
    plat_rst_lvl = l; plat_rst_upd = 1;
    step(1);
    plat_rst_upd = 0;
  endtask

  task automatic t_plat();
    upd(1'b1);
    chk("R9 known", {31'h0, plat_rst_known}, 32'h1);
    chk("R9 val1", {31'h0, plat_rst_val}, 32'h1);
    chk("R9 first chg", {31'h0, plat_rst_chg}, 32'h1);
    step(1);
    chk("R10 chg one cycle", {31'h0, plat_rst_chg}, 32'h0);
    upd(1'b1);
    chk("R10 same level no chg", {31'h0, plat_rst_chg}, 32'h0);
    upd(1'b0);
    chk("R10 new level chg", {31'h0, plat_rst_chg}, 32'h1);
    chk("R10 val0", {31'h0, plat_rst_val}, 32'h0);
    t_reset();
    upd(1'b0);
    chk("R9 first report 0 chg", {31'h0, plat_rst_chg}, 32'h1);
    chk("R9 first report known", {31'h0, plat_rst_known}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_host();
    t_oob();
    t_sus();
    t_pwr();
    t_hwrst();
    t_plat();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule